// File: doc/BRIEF.md
# Program/Erase Status Engine

This block runs one byte program or one range erase over a fixed number of clock cycles on a small, parameterised memory array. While the operation runs, it reports progress on the ordinary read path, the way parallel flash status polling works. Cells are erased to all ones. A program can only clear bits, so the stored byte becomes the AND of the old and new data. An erase sets every byte in an inclusive address range back to 0xFF.

A write is requested through active-low chip enable, output enable and write enable strobes. `op_erase` chooses the operation (0 = byte program, 1 = range erase). A digital glitch filter keeps short strobe pulses from starting anything. While `busy` is high, a read returns status bits instead of plain data:
- bit 6 flips on every read;
- during a program, a read of the loaded address returns the complement of the loaded bit 7 on bit 7.

When the operation ends, reads return the true stored byte again.

Top module: `flash_status_engine`

## Requirements
- R1: After reset `busy` is low and every address reads 0xFF.
- R2: A completed byte program leaves the stored byte equal to the old byte AND `wdata`; bits can only go from 1 to 0.
- R3: While a program is busy, a read of the programmed address returns on bit 7 the complement of bit 7 of the loaded `wdata`.
- R4: While any operation is busy, each read returns bit 6 inverted from the previous busy read.
- R5: After completion, reads return the true stored byte on all bits, and repeated reads return the same bit 6.
- R6: A write starts only while `ce_n`=0, `oe_n`=1 and `we_n`=0. If `oe_n` is low or `ce_n` is high, the strobe does nothing and memory is unchanged.
- R7: The qualified strobe must hold for FILT consecutive clock edges. A shorter pulse starts nothing. A longer pulse starts exactly one operation, on its FILT-th edge.
- R8: A program keeps `busy` high for exactly PROG_CYCLES cycles, starting right after the FILT-th strobe edge.
- R9: An erase sets every byte with `sec_lo` <= address <= `sec_hi` to 0xFF, leaves all other bytes unchanged, and holds `busy` for exactly ERASE_CYCLES cycles.
- R10: A write request made while `busy` is high is refused and changes no data.
- R11: `rdata` is registered. It updates on the clock edge where `rd` is high and holds its value otherwise.
- R12: A busy read of any address other than a program's target, and any read during an erase, returns the stored bits 7 and 5..0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write strobe, active low |
| op_erase | input | 1 | 0 = byte program, 1 = range erase |
| addr | input | AW | Read address and program address |
| wdata | input | DW | Byte to program |
| sec_lo | input | AW | First address of the erase range |
| sec_hi | input | AW | Last address of the erase range (inclusive) |
| rd | input | 1 | Read strobe, one cycle |
| rdata | output | DW | Registered read data or status |
| busy | output | 1 | Operation in progress |

## Verification
The bench targets the following corner cases:
- Strobes of FILT-1 and FILT cycles. A filter off by one either starts on a glitch or never starts on a legal pulse.
- Strobes held with `oe_n` low or `ce_n` high. A design that ignores the inhibit would rise `busy` and corrupt the target byte.
- Back-to-back reads inside one busy window. A design that toggles bit 6 per cycle, instead of per read, would repeat a value.
- Polling the target address with loaded bit 7 both set and clear, which catches a design that returns the raw or stored bit.
- Erase ranges at their exact edges, plus a program issued mid-erase. An inclusive/exclusive mixup leaves a boundary byte wrong. A design that accepts requests while busy would shorten the erase or write the byte.

// File: rtl/flash_status_engine.sv
module flash_status_engine #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int FILT = 3,
  parameter int PROG_CYCLES = 2500,
  parameter int ERASE_CYCLES = 750000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          op_erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] sec_lo,
  input  logic [AW-1:0] sec_hi,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int FW    = $clog2(FILT + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [FW-1:0] gcnt;
  logic [CW-1:0] cnt;
  logic          is_erase, tog;
  logic [AW-1:0] la, lo, hi;
  logic [DW-1:0] ld, view;

  wire qual  = ~ce_n & oe_n & ~we_n;
  wire start = qual && (gcnt == FW'(FILT - 1)) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)          gcnt <= '0;
    else if (!qual)      gcnt <= '0;
    else if (gcnt != FW'(FILT)) gcnt <= gcnt + 1'b1;
  end

  always_comb begin
    view = mem[addr];
    if (busy) begin
      view[6] = tog;
      if (!is_erase && addr == la) view[7] = ~ld[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; is_erase <= 1'b0; tog <= 1'b0;
      la <= '0; lo <= '0; hi <= '0; ld <= '0; rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (rd) begin
        rdata <= view;
        if (busy) tog <= ~tog;
      end
      if (start) begin
        busy <= 1'b1; is_erase <= op_erase;
        la <= addr; ld <= wdata; lo <= sec_lo; hi <= sec_hi;
        cnt <= op_erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (is_erase) begin
            for (int i = 0; i < DEPTH; i++)
              if (AW'(i) >= lo && AW'(i) <= hi) mem[i] <= '1;
          end else begin
            mem[la] <= mem[la] & ld;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_status_engine_chk.sv
module flash_status_engine_chk #(
  parameter int FILT = 3,
  parameter int PROG_CYCLES = 2500,
  parameter int ERASE_CYCLES = 750000000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic rd,
  input logic b6,
  input logic busy
);
  int   qrun, brun;
  logic rdq, have, prev6;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qrun <= 0; brun <= 0; rdq <= 1'b0; have <= 1'b0; prev6 <= 1'b0;
    end else begin
      if (!(~ce_n & oe_n & ~we_n)) qrun <= 0;
      else if (qrun < FILT) qrun <= qrun + 1;
      brun <= busy ? brun + 1 : 0;
      rdq <= busy && rd;
      if (rdq) begin prev6 <= b6; have <= 1'b1; end
      else if (!busy) have <= 1'b0;
    end
  end

  assert_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> qrun == FILT);
  assert_duration_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (brun == PROG_CYCLES || brun == ERASE_CYCLES));
  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && have) |-> b6 != prev6);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd) && !$past(!rst_n)) |-> $stable(b6));
endmodule

bind flash_status_engine flash_status_engine_chk #(
  .FILT(FILT), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .rd(rd), .b6(rdata[6]), .busy(busy)
);

// File: tb/flash_status_engine_tb_top.sv
module flash_status_engine_tb_top;
  localparam int AW = 6, DW = 8, FILT = 3, PROG = 16, ERASE = 48;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, op_erase = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0, sec_lo = '0, sec_hi = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic busy;

  flash_status_engine #(.AW(AW), .DW(DW), .FILT(FILT), .PROG_CYCLES(PROG),
    .ERASE_CYCLES(ERASE)) dut_i (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, run = 0, last_run = 0;
  logic [7:0] m [DEPTH];
  logic tog_m = 1'b0;
  logic [7:0] cur_d;
  logic [AW-1:0] cur_a;
  bit cur_prog = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit er, logic [AW-1:0] a, logic [7:0] d, logic [AW-1:0] lo,
                    logic [AW-1:0] hi, int len, bit oe_low, bit ce_high);
    @(negedge clk);
    op_erase = er; addr = a; wdata = d; sec_lo = lo; sec_hi = hi;
    ce_n = ce_high; oe_n = ~oe_low; we_n = 1'b0;
    repeat (len) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rdx(logic [AW-1:0] a, output logic [7:0] v, output logic [7:0] e);
    logic b;
    @(negedge clk);
    addr = a; rd = 1'b1; b = busy;
    e = m[a];
    if (b) begin
      e[6] = tog_m;
      if (cur_prog && a == cur_a) e[7] = ~cur_d[7];
      tog_m = ~tog_m;
    end
    @(negedge clk);
    rd = 1'b0; v = rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d, int polls);
    logic [7:0] v, e;
    wr(1'b0, a, d, '0, '0, FILT, 1'b0, 1'b0);
    cur_prog = 1'b1; cur_a = a; cur_d = d;
    check("R8 busy after strobe", busy, 1);
    for (int k = 0; k < polls; k++) begin
      logic [AW-1:0] ra = (k % 2 == 0) ? a : AW'($urandom_range(0, DEPTH - 1));
      rdx(ra, v, e);
      check((ra == a) ? "R3/R4 poll target" : "R4/R12 poll other", v, e);
    end
    wait_idle();
    cur_prog = 1'b0;
    m[a] = m[a] & d;
    @(negedge clk);
    check("R8 program length", last_run, PROG);
  endtask

  task automatic erase(logic [AW-1:0] lo, logic [AW-1:0] hi, int polls);
    logic [7:0] v, e;
    wr(1'b1, '0, '0, lo, hi, FILT, 1'b0, 1'b0);
    check("R9 busy after strobe", busy, 1);
    for (int k = 0; k < polls; k++) begin
      logic [AW-1:0] ra = AW'($urandom_range(0, DEPTH - 1));
      rdx(ra, v, e);
      check("R4/R12 erase poll", v, e);
    end
    wait_idle();
    for (int i = 0; i < DEPTH; i++) if (i >= lo && i <= hi) m[i] = 8'hFF;
    @(negedge clk);
    check("R9 erase length", last_run, ERASE);
  endtask

  initial begin
    logic [7:0] v, e, v2;
    void'($urandom(32'd20250611));
    for (int i = 0; i < DEPTH; i++) m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    rdx(6'd5, v, e); check("R1 erased read", v, 8'hFF);

    prog(6'd5, 8'hA5, 4);
    rdx(6'd5, v, e); check("R5 true data after program", v, 8'hA5);
    rdx(6'd5, v2, e); check("R5 bit6 steady", v2, v);

    prog(6'd5, 8'h3C, 3);
    rdx(6'd5, v, e); check("R2 AND result", v, 8'h24);

    wr(1'b0, 6'd5, 8'h00, '0, '0, 6, 1'b1, 1'b0);
    check("R6 oe low blocks", busy, 0);
    wr(1'b0, 6'd5, 8'h00, '0, '0, 6, 1'b0, 1'b1);
    check("R6 ce high blocks", busy, 0);
    rdx(6'd5, v, e); check("R6 memory unchanged", v, 8'h24);

    wr(1'b0, 6'd9, 8'h0F, '0, '0, FILT - 1, 1'b0, 1'b0);
    check("R7 short pulse ignored", busy, 0);
    @(negedge clk); check("R7 still idle", busy, 0);
    rdx(6'd9, v, e); check("R7 memory unchanged", v, 8'hFF);
    wr(1'b0, 6'd9, 8'h0F, '0, '0, FILT + 4, 1'b0, 1'b0);
    check("R7 long pulse starts", busy, 1);
    cur_prog = 1'b1; cur_a = 6'd9; cur_d = 8'h0F;
    wait_idle(); cur_prog = 1'b0; m[9] = 8'h0F;
    @(negedge clk);
    check("R7 one op per pulse", busy, 0);
    check("R7/R8 length", last_run, PROG);

    prog(6'd7, 8'h11, 0); prog(6'd8, 8'h22, 0); prog(6'd15, 8'h33, 0); prog(6'd16, 8'h44, 0);
    wr(1'b1, '0, '0, 6'd8, 6'd15, FILT, 1'b0, 1'b0);
    rdx(6'd8, v, e); check("R12 erase poll bit7 stored", v, e);
    rdx(6'd8, v, e); check("R4 erase poll toggles", v, e);
    wr(1'b0, 6'd20, 8'h00, '0, '0, FILT, 1'b0, 1'b0);
    wait_idle();
    for (int i = 8; i <= 15; i++) m[i] = 8'hFF;
    @(negedge clk);
    check("R10 erase not shortened", last_run, ERASE);
    rdx(6'd20, v, e); check("R10 refused write", v, 8'hFF);
    rdx(6'd7, v, e);  check("R9 below range kept", v, 8'h11);
    rdx(6'd8, v, e);  check("R9 low edge erased", v, 8'hFF);
    rdx(6'd15, v, e); check("R9 high edge erased", v, 8'hFF);
    rdx(6'd16, v, e); check("R9 above range kept", v, 8'h44);

    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 4) == 0) begin
        logic [AW-1:0] lo = AW'($urandom_range(0, DEPTH - 1));
        logic [AW-1:0] hi = AW'($urandom_range(lo, DEPTH - 1));
        erase(lo, hi, $urandom_range(0, 3));
      end else begin
        prog(AW'($urandom_range(0, DEPTH - 1)), 8'($urandom), $urandom_range(0, 3));
      end
      begin
        logic [AW-1:0] ra = AW'($urandom_range(0, DEPTH - 1));
        rdx(ra, v, e); check("R2/R5/R9 random readback", v, e);
        @(negedge clk);
        check("R11 rdata held without rd", rdata, v);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule